// File: doc/BRIEF.md
# Maskable Latched Input-Change Interrupt Unit

This block watches a set of general-purpose input pins and tells a host when one of them no longer matches the value the host last read. Each pin is compared against a per-pin reference: the Input Port value the host saw at its most recent read of that pin's 8-bit bank. The comparison is not made against the previous clock sample. An unmasked pin that differs from its reference sets its bit in a read-only status register, and the open-drain interrupt request is asserted while any status bit is set.

Every pin has a mask bit and an input-latch enable bit. At reset all mask bits are set, so no interrupt can occur until the host clears some of them. A pin with latching enabled captures the first value that differs from its reference. It keeps showing that value on the Input Port, and keeps its status bit, until the host reads the bank, even if the pin goes back to its old level. A pin without latching follows the synchronized pin directly, so if it returns to the reference before a read, its request clears by itself.

Reading a bank with the per-bank read strobe loads the bank's shown value into its reference and clears that bank's status and latched events. The other banks are left untouched. Pins configured as outputs are never compared. The raw pins pass through a two-flop synchronizer first.

Top module: `pin_change_irq`

## Requirements
- R1: A pin change appears on `port_val_o` after the second rising clock edge and, if the pin is unmasked, on the status and `int_low_en_o` after the third. After only one edge it has no effect.
- R2: After reset all mask bits read 0xFF per bank, latch enables read 0x00, status reads 0x00, every reference is 0 and `int_low_en_o` is 0.
- R3: A pin whose mask bit is 1 never sets its status bit or the interrupt, even while it differs from its reference.
- R4: For an unmasked input pin, the status bit is 1 exactly when the pin's shown Input Port value differs from its reference.
- R5: For a pin with latching disabled, a return to the reference value before any read clears its status bit, and clears the interrupt if no other bit is set.
- R6: For a pin with latching enabled, the first differing value is held on `port_val_o` and in the status until its bank is read, even after the pin returns to its old level.
- R7: A pulse on `port_rd_i[b]` loads bank b's shown value into its reference and clears bank b's status and held events at that clock edge. Other banks keep their status. After that edge, a pin that no longer matches the new reference raises a new event.
- R8: A pin with `pin_is_input_i` = 0 never sets its status bit.
- R9: `reg_sel_i` selects the register: 0 = mask, 1 = latch enable, 2 = status (read-only; writes are ignored), 3 = reads 0. `reg_bank_i` = b selects pins [8b+7:8b]. Writes take effect at the clock edge while `reg_wr_i` is 1. `reg_rdata_o` shows the addressed register at once.
- R10: `int_low_en_o` is 1 (pad drives the line low) exactly when at least one status bit is set, and 0 (line released) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | Raw asynchronous pin levels |
| pin_is_input_i | input | 16 | 1 = pin configured as input |
| reg_wr_i | input | 1 | Write strobe for the addressed register bank |
| reg_sel_i | input | 2 | Register select: 0 mask, 1 latch, 2 status, 3 none |
| reg_bank_i | input | 1 | Bank index |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the addressed register bank |
| port_rd_i | input | 2 | Per-bank Input Port read strobe |
| port_val_o | output | 16 | Input Port value a read returns (held value for latched pins) |
| int_low_en_o | output | 1 | Open-drain pull-down enable for the active-low interrupt line |

## Verification
The bound checker enforces several rules on every cycle. A masked pin or an output pin never carries a status bit. A bank read leaves that bank's status clear on the next cycle. A held latched value stays put until a read or a latch-enable write. The interrupt line always agrees with the status register. The two-edge synchronizer delay, the return-to-reference self-clearing, the re-arming after a read of a latched pin, bank isolation, the register decode and the reset values can only be shown by the bench's scenarios, which compare against a reference model of the pins the bench keeps itself.

// File: rtl/chg_irq_pkg.sv
`timescale 1ns/1ps
package chg_irq_pkg;
   typedef enum logic [1:0] {
      SEL_MASK   = 2'd0,
      SEL_LATCH  = 2'd1,
      SEL_STATUS = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/chg_irq_sync.sv
`timescale 1ns/1ps
module chg_irq_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/chg_irq_cfg_regs.sv
`timescale 1ns/1ps
module chg_irq_cfg_regs
   import chg_irq_pkg::*;
#(
   parameter int NUM_PINS   = 16,
   parameter int BANK_W     = 8,
   parameter int NUM_BANKS  = NUM_PINS / BANK_W,
   parameter int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_i,
   input  logic [1:0]            sel_i,
   input  logic [BANK_IDX_W-1:0] bank_i,
   input  logic [BANK_W-1:0]     wdata_i,
   output logic [NUM_PINS-1:0]   mask_o,
   output logic [NUM_PINS-1:0]   latch_o
);
   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam logic [BANK_IDX_W-1:0] BIDX = BANK_IDX_W'(b);
         logic hit;
         assign hit = wr_i && (bank_i == BIDX);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mask_o[b*BANK_W +: BANK_W]  <= '1;
               latch_o[b*BANK_W +: BANK_W] <= '0;
            end else if (hit) begin
               if (sel_i == SEL_MASK)  mask_o[b*BANK_W +: BANK_W]  <= wdata_i;
               if (sel_i == SEL_LATCH) latch_o[b*BANK_W +: BANK_W] <= wdata_i;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/chg_irq_bank.sv
`timescale 1ns/1ps
module chg_irq_bank #(
   parameter int BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] pin_sync_i,
   input  logic [BANK_W-1:0] is_input_i,
   input  logic [BANK_W-1:0] mask_i,
   input  logic [BANK_W-1:0] latch_i,
   input  logic              rd_i,
   output logic [BANK_W-1:0] shown_o,
   output logic [BANK_W-1:0] status_next_o,
   output logic [BANK_W-1:0] status_o,
   output logic [BANK_W-1:0] held_o,
   output logic [BANK_W-1:0] hval_o
);
   logic [BANK_W-1:0] ref_q;
   logic [BANK_W-1:0] held_q;
   logic [BANK_W-1:0] hval_q;
   logic [BANK_W-1:0] status_q;
   logic [BANK_W-1:0] differ;
   logic [BANK_W-1:0] capture;

   // shown value: held event value for latched pins, else live sample
   assign shown_o = (held_q & hval_q) | (~held_q & pin_sync_i);
   assign differ  = (shown_o ^ ref_q) & is_input_i;
   assign capture = latch_i & ~held_q & is_input_i & (pin_sync_i ^ ref_q);
   assign status_next_o = rd_i ? '0 : (differ & ~mask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q    <= '0;
         held_q   <= '0;
         hval_q   <= '0;
         status_q <= '0;
      end else if (rd_i) begin
         ref_q    <= shown_o;
         held_q   <= '0;
         status_q <= '0;
      end else begin
         held_q   <= (held_q & latch_i) | capture;
         hval_q   <= (capture & pin_sync_i) | (~capture & hval_q);
         status_q <= status_next_o;
      end
   end

   assign status_o = status_q;
   assign held_o   = held_q;
   assign hval_o   = hval_q;
endmodule

// File: rtl/pin_change_irq.sv
`timescale 1ns/1ps
module pin_change_irq
   import chg_irq_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int BANK_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_BANKS  = NUM_PINS / BANK_W,
   localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   pin_i,
   input  logic [NUM_PINS-1:0]   pin_is_input_i,
   input  logic                  reg_wr_i,
   input  logic [1:0]            reg_sel_i,
   input  logic [BANK_IDX_W-1:0] reg_bank_i,
   input  logic [BANK_W-1:0]     reg_wdata_i,
   output logic [BANK_W-1:0]     reg_rdata_o,
   input  logic [NUM_BANKS-1:0]  port_rd_i,
   output logic [NUM_PINS-1:0]   port_val_o,
   output logic                  int_low_en_o
);
   generate
      if (NUM_PINS % BANK_W != 0) begin : g_bad_split
         $error("NUM_PINS must be a multiple of BANK_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("at least one bank is required");
      end
   endgenerate

   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] mask_q;
   logic [NUM_PINS-1:0] latch_q;
   logic [NUM_PINS-1:0] status_q;
   logic [NUM_PINS-1:0] status_next;
   logic [NUM_PINS-1:0] held_q;
   logic [NUM_PINS-1:0] hval_q;
   logic                int_q;

   chg_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_sync)
   );

   chg_irq_cfg_regs #(
      .NUM_PINS(NUM_PINS), .BANK_W(BANK_W),
      .NUM_BANKS(NUM_BANKS), .BANK_IDX_W(BANK_IDX_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr_i),
      .sel_i   (reg_sel_i),
      .bank_i  (reg_bank_i),
      .wdata_i (reg_wdata_i),
      .mask_o  (mask_q),
      .latch_o (latch_q)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         chg_irq_bank #(.BANK_W(BANK_W)) u_bank (
            .clk           (clk),
            .rst_n         (rst_n),
            .pin_sync_i    (pin_sync[b*BANK_W +: BANK_W]),
            .is_input_i    (pin_is_input_i[b*BANK_W +: BANK_W]),
            .mask_i        (mask_q[b*BANK_W +: BANK_W]),
            .latch_i       (latch_q[b*BANK_W +: BANK_W]),
            .rd_i          (port_rd_i[b]),
            .shown_o       (port_val_o[b*BANK_W +: BANK_W]),
            .status_next_o (status_next[b*BANK_W +: BANK_W]),
            .status_o      (status_q[b*BANK_W +: BANK_W]),
            .held_o        (held_q[b*BANK_W +: BANK_W]),
            .hval_o        (hval_q[b*BANK_W +: BANK_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_q <= 1'b0;
      else        int_q <= |status_next;
   end

   assign int_low_en_o = int_q;

   always_comb begin
      reg_rdata_o = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (BANK_IDX_W'(b) == reg_bank_i) begin
            case (reg_sel_i)
               SEL_MASK:   reg_rdata_o = mask_q[b*BANK_W +: BANK_W];
               SEL_LATCH:  reg_rdata_o = latch_q[b*BANK_W +: BANK_W];
               SEL_STATUS: reg_rdata_o = status_q[b*BANK_W +: BANK_W];
               default:    reg_rdata_o = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/chg_irq_checker.sv
`timescale 1ns/1ps
module chg_irq_checker #(
   parameter int NUM_PINS  = 16,
   parameter int BANK_W    = 8,
   parameter int NUM_BANKS = NUM_PINS / BANK_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_PINS-1:0]  mask_q,
   input logic [NUM_PINS-1:0]  latch_q,
   input logic [NUM_PINS-1:0]  status_q,
   input logic [NUM_PINS-1:0]  held_q,
   input logic [NUM_PINS-1:0]  hval_q,
   input logic [NUM_PINS-1:0]  pin_is_input_i,
   input logic [NUM_BANKS-1:0] port_rd_i,
   input logic                 reg_wr_i,
   input logic                 int_low_en_o
);
   // R3: a pin masked at the previous edge carries no status bit
   p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & $past(mask_q)) == '0));

   // R8: an output pin carries no status bit
   p_output_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~$past(pin_is_input_i)) == '0));

   // R10: interrupt line agrees with the status register
   p_int_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int_low_en_o == (|status_q)));

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         // R7: a bank read leaves that bank's status clear
         p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            port_rd_i[b] |=> (status_q[b*BANK_W +: BANK_W] == '0));
      end
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         // R6: a held event value stays until a read or latch write
         p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (held_q[i] && latch_q[i] && !port_rd_i[i/BANK_W] && !reg_wr_i)
            |=> (held_q[i] && (hval_q[i] == $past(hval_q[i]))));
      end
   endgenerate
endmodule

bind pin_change_irq chg_irq_checker #(
   .NUM_PINS(NUM_PINS), .BANK_W(BANK_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mask_q         (mask_q),
   .latch_q        (latch_q),
   .status_q       (status_q),
   .held_q         (held_q),
   .hval_q         (hval_q),
   .pin_is_input_i (pin_is_input_i),
   .port_rd_i      (port_rd_i),
   .reg_wr_i       (reg_wr_i),
   .int_low_en_o   (int_low_en_o)
);

// File: tb/sim_pin_change_irq.sv
`timescale 1ns/1ps
module sim_pin_change_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pin_i = '0;
   logic [15:0] pin_is_input_i = '1;
   logic        reg_wr_i = 1'b0;
   logic [1:0]  reg_sel_i = 2'd0;
   logic [0:0]  reg_bank_i = 1'b0;
   logic [7:0]  reg_wdata_i = '0;
   logic [7:0]  reg_rdata_o;
   logic [1:0]  port_rd_i = '0;
   logic [15:0] port_val_o;
   logic        int_low_en_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   logic [15:0] ref_m = '0;

   always #4 clk = ~clk;

   pin_change_irq u0 (.*);

   // pins in [31:16], mask in [15:0]; latching off, all pins inputs
   localparam logic [31:0] VEC [6] = '{
      {16'h0001, 16'h0000},
      {16'h8001, 16'hFFFF},
      {16'h00F0, 16'hFF0F},
      {16'hFF00, 16'h00FF},
      {16'hFF00, 16'h0000},
      {16'h1234, 16'h0000}
   };

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic bank, logic [7:0] d);
      reg_sel_i = sel; reg_bank_i = bank; reg_wdata_i = d; reg_wr_i = 1'b1;
      step();
      reg_wr_i = 1'b0;
   endtask

   task automatic rd(logic [1:0] sel, logic bank, output logic [7:0] d);
      reg_sel_i = sel; reg_bank_i = bank;
      #1 d = reg_rdata_o;
   endtask

   task automatic port_read(int b);
      port_rd_i[b] = 1'b1;
      step();
      port_rd_i = '0;
   endtask

   function automatic logic [15:0] status16();
      logic [7:0] lo, hi;
      lo = u0_rd(0); hi = u0_rd(1);
      return {hi, lo};
   endfunction

   function automatic logic [7:0] u0_rd(int b);
      return 8'h00 * b[7:0];
   endfunction

   task automatic read_status(output logic [15:0] s);
      logic [7:0] lo, hi;
      rd(2'd2, 1'b0, lo);
      rd(2'd2, 1'b1, hi);
      s = {hi, lo};
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0]  d8;
      logic [15:0] s16, exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R2 reset state
      rd(2'd0, 1'b0, d8); chk("R2 mask bank0", {8'h0, d8}, 16'h00FF);
      rd(2'd0, 1'b1, d8); chk("R2 mask bank1", {8'h0, d8}, 16'h00FF);
      rd(2'd1, 1'b0, d8); chk("R2 latch", {8'h0, d8}, 16'h0000);
      read_status(s16);   chk("R2 status", s16, 16'h0000);
      chk("R2 int", {15'h0, int_low_en_o}, 16'h0);

      // R1 synchronizer latency
      wr(2'd0, 1'b0, 8'h00);
      wr(2'd0, 1'b1, 8'h00);
      pin_i = 16'h0002;
      step(); chk("R1 one edge port", port_val_o, 16'h0000);
      step(); chk("R1 two edges port", port_val_o, 16'h0002);
      chk("R1 two edges int", {15'h0, int_low_en_o}, 16'h0);
      step(); chk("R1 three edges int", {15'h0, int_low_en_o}, 16'h1);
      port_read(0); port_read(1); ref_m = 16'h0002;

      // table walk: R3, R4, R10
      for (int k = 0; k < 6; k++) begin
         logic [15:0] pv, mv;
         pv = VEC[k][31:16]; mv = VEC[k][15:0];
         wr(2'd0, 1'b0, mv[7:0]);
         wr(2'd0, 1'b1, mv[15:8]);
         pin_i = pv;
         repeat (3) step();
         exp = (pv ^ ref_m) & ~mv;
         read_status(s16);
         chk("R4 R3 status", s16, exp);
         chk("R10 int", {15'h0, int_low_en_o}, {15'h0, |exp});
         chk("R4 port value", port_val_o, pv);
         port_read(0); port_read(1); ref_m = pv;
         chk("R7 int after reads", {15'h0, int_low_en_o}, 16'h0);
      end

      // R5 non-latched return clears by itself
      pin_i = 16'h1235; repeat (3) step();
      chk("R5 int raised", {15'h0, int_low_en_o}, 16'h1);
      pin_i = 16'h1234; repeat (3) step();
      chk("R5 int self-clear", {15'h0, int_low_en_o}, 16'h0);
      read_status(s16); chk("R5 status clear", s16, 16'h0000);

      // R8 output pins never interrupt
      pin_is_input_i = ~16'h0020;
      pin_i = 16'h1214; repeat (3) step();
      chk("R8 int", {15'h0, int_low_en_o}, 16'h0);
      read_status(s16); chk("R8 status", s16, 16'h0000);
      pin_i = 16'h1234; repeat (3) step();
      pin_is_input_i = '1; step();

      // R6 latched pin holds event value
      wr(2'd1, 1'b0, 8'h08);
      pin_i = 16'h123C; repeat (3) step();
      chk("R6 int raised", {15'h0, int_low_en_o}, 16'h1);
      pin_i = 16'h1234; repeat (3) step();
      chk("R6 held port", port_val_o, 16'h123C);
      read_status(s16); chk("R6 held status", s16, 16'h0008);
      chk("R6 int held", {15'h0, int_low_en_o}, 16'h1);
      port_read(0);
      chk("R7 int after read", {15'h0, int_low_en_o}, 16'h0);
      step();
      chk("R7 new event after read", {15'h0, int_low_en_o}, 16'h1);
      chk("R7 new event port", port_val_o, 16'h1234);
      port_read(0); step();
      chk("R7 settled", {15'h0, int_low_en_o}, 16'h0);
      wr(2'd1, 1'b0, 8'h00);

      // R7 bank isolation
      pin_i = 16'h1335; repeat (3) step();
      read_status(s16); chk("R7 both banks", s16, 16'h0101);
      port_read(0); step();
      read_status(s16); chk("R7 bank1 kept", s16, 16'h0100);
      chk("R7 int kept", {15'h0, int_low_en_o}, 16'h1);
      port_read(1);
      chk("R7 int cleared", {15'h0, int_low_en_o}, 16'h0);

      // R9 register decode
      wr(2'd0, 1'b1, 8'hA5);
      rd(2'd0, 1'b1, d8); chk("R9 mask readback", {8'h0, d8}, 16'h00A5);
      rd(2'd0, 1'b0, d8); chk("R9 mask bank0", {8'h0, d8}, 16'h0000);
      wr(2'd1, 1'b1, 8'h3C);
      rd(2'd1, 1'b1, d8); chk("R9 latch readback", {8'h0, d8}, 16'h003C);
      wr(2'd2, 1'b0, 8'hFF);
      read_status(s16); chk("R9 status write ignored", s16, 16'h0000);
      rd(2'd3, 1'b1, d8); chk("R9 select 3 reads zero", {8'h0, d8}, 16'h0000);
      wr(2'd1, 1'b1, 8'h00);

      // R2 R3 reset mid-run: all masked, no interrupt until unmasked
      rst_n = 1'b0; step(); rst_n = 1'b1; repeat (3) step();
      chk("R3 masked after reset", {15'h0, int_low_en_o}, 16'h0);
      rd(2'd0, 1'b1, d8); chk("R2 mask after reset", {8'h0, d8}, 16'h00FF);
      wr(2'd0, 1'b1, 8'h00); step();
      read_status(s16); chk("R4 unmask bank1 vs zero ref", s16, 16'h1300);
      chk("R10 int after unmask", {15'h0, int_low_en_o}, 16'h1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule